// File: doc/BRIEF.md
# Vector Priority and Acknowledge Core

This block keeps the interrupt state of one processor's local interrupt controller: a pending set, an in-service set and a trigger-mode set with one bit for each of 256 vectors. Request ports post vectors tagged edge or level. The core derives a processor priority from a task-priority register and from the highest vector in service. It raises its interrupt output while the best pending vector sits in a higher 16-vector priority class than that priority.

The processor takes an interrupt with an acknowledge pulse, which returns one of three results: nothing, the spurious vector, or a real vector. A real vector moves from pending to in service. A completion write retires the highest in-service vector. When that vector was level-triggered and directed completion is off, the core emits a one-cycle broadcast that carries the vector number, so that the interrupt sources can re-arm.

Top module: `irq_prio_core`

## Requirements
- R1: A request sets the pending bit of `req_vec`. It sets that vector's trigger bit when `req_level` is 1 and clears it when `req_level` is 0.
- R2: Among the pending vectors, the one with the highest number is the only candidate for delivery.
- R3: Processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by a zero low nibble. An empty in-service set counts as class 0.
- R4: The candidate is deliverable when processor priority is zero, or when the candidate's class (bits 7:4) is strictly greater than the processor-priority class.
- R5: Every `ack_req` pulse produces `ack_valid` one cycle later. `ack_none` is 1 when nothing is pending.
- R6: When the candidate is not deliverable, the acknowledge returns the spurious vector (configuration bits 7:0) with `ack_none` at 0, and leaves the pending set unchanged.
- R7: When the candidate is deliverable, the acknowledge returns it, clears its pending bit and sets its in-service bit.
- R8: A completion write clears the highest in-service bit. If that vector's trigger bit is 1 and configuration bit 12 (directed completion) is 0, `eoi_bcast_valid` pulses one cycle later with `eoi_bcast_vec` set to that vector.
- R9: A configuration write keeps only bits 8:0 and bit 12. Bit 8 is the enable. While the enable is 0, `irq_out` stays low and every acknowledge returns `ack_none`. The reset value is 0x0FF, which is disabled.
- R10: A completion write while the in-service set is empty changes nothing and produces no broadcast.
- R11: When a request and an acknowledge fall in the same cycle, the acknowledge acts on the state from before the request, and the request is applied afterwards.
- R12: `irq_out` is registered. It reflects the state one clock edge after a state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Vector request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge pulse |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_none | output | 1 | Nothing to deliver |
| ack_vec | output | 8 | Returned vector (real or spurious) |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority value |
| cfg_we | input | 1 | Spurious/configuration write strobe |
| cfg_wdata | input | 16 | Configuration value |
| eoi_we | input | 1 | Completion write strobe |
| irq_out | output | 1 | Interrupt to the processor |
| eoi_bcast_valid | output | 1 | Level completion broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector being broadcast |

## Verification
The functions that can collide are posting a request and acknowledging. Both change the pending set, and both can target the same vector in the same cycle. The bench raises `req_valid` and `ack_req` together while the pending set is empty. It then checks that this acknowledge reports nothing and that the next acknowledge returns the new vector, which shows the request was applied after the acknowledge had made its choice. A completion write issued in the same cycle as a pending request is also exercised, and the broadcast is judged against the trigger bit that was stored before that request.

// File: rtl/irq_core_pkg.sv
// Package: shared types and helpers for the vector priority core.
// Assumes vector numbers whose top four bits form the priority class.
package irq_core_pkg;
    typedef enum logic [1:0] {
        ACK_EMPTY = 2'd0,
        ACK_SPUR  = 2'd1,
        ACK_TAKE  = 2'd2
    } ack_kind_e;

    localparam int CLASS_W = 4;
endpackage

// File: rtl/hi_bit_enc.sv
// Highest-set-bit encoder over a wide vector, split into words.
// Each word is searched in parallel, then the highest non-empty word wins.
// Assumes N is a multiple of WORD and holds at least two words.
module hi_bit_enc #(
    parameter int N    = 256,
    parameter int WORD = 32,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    localparam int NW  = N / WORD;
    localparam int BW  = $clog2(WORD);
    localparam int WIW = $clog2(NW);

    logic [NW-1:0] w_found;
    logic [BW-1:0] w_idx [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic          f;
        logic [BW-1:0] i;
        // Find the highest set bit inside this word.
        always_comb begin
            f = 1'b0;
            i = '0;
            for (int b = 0; b < WORD; b++) begin
                if (vec_i[w*WORD + b]) begin
                    f = 1'b1;
                    i = BW'(b);
                end
            end
        end
        assign w_found[w] = f;
        assign w_idx[w]   = i;
    end

    // Pick the highest word that holds a set bit.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int w = 0; w < NW; w++) begin
            if (w_found[w]) begin
                found_o = 1'b1;
                idx_o   = {WIW'(w), w_idx[w]};
            end
        end
    end
endmodule

// File: rtl/prio_gate.sv
// Derives the processor priority from the task priority and the highest
// in-service vector, and decides whether the best pending vector may go.
// Assumes the class is the top CLASS_W bits of a vector number.
module prio_gate
    import irq_core_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic [VW-1:0] tpr_i,
    input  logic          isr_found_i,
    input  logic [VW-1:0] isr_idx_i,
    input  logic          irr_found_i,
    input  logic [VW-1:0] irr_idx_i,
    output logic [VW-1:0] ppr_o,
    output logic          deliver_o
);
    localparam int LOW_W = VW - CLASS_W;

    logic [CLASS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

    // Processor priority: the larger of task class and in-service class.
    always_comb begin
        tpr_cls = tpr_i[VW-1 -: CLASS_W];
        isr_cls = isr_found_i ? isr_idx_i[VW-1 -: CLASS_W] : '0;
        ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LOW_W{1'b0}}};
    end

    // Delivery gate: zero priority lets anything pass, else strict class compare.
    always_comb begin
        irr_cls   = irr_idx_i[VW-1 -: CLASS_W];
        ppr_cls   = ppr_o[VW-1 -: CLASS_W];
        deliver_o = irr_found_i && ((ppr_o == '0) || (irr_cls > ppr_cls));
    end
endmodule

// File: rtl/irq_prio_core.sv
// Vector priority and acknowledge core.
// Holds pending, in-service and trigger sets, serves acknowledge and
// completion cycles and drives a registered interrupt output.
// Same-cycle order: completion clear, then acknowledge, then request.
module irq_prio_core
    import irq_core_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int WORD      = 32,
    parameter int CFG_W     = 16,
    parameter int DEOI_BIT  = 12,
    localparam int VW       = $clog2(NUM_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vec,
    input  logic          req_level,
    input  logic          ack_req,
    output logic          ack_valid,
    output logic          ack_none,
    output logic [VW-1:0] ack_vec,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    input  logic          cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic          eoi_we,
    output logic          irq_out,
    output logic          eoi_bcast_valid,
    output logic [VW-1:0] eoi_bcast_vec
);
    localparam logic [VW:0] CFG_RST = {1'b0, {VW{1'b1}}};

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
    logic [VW-1:0]      tpr_q;
    logic [VW:0]        cfg_q;
    logic               deoi_q;
    logic               sw_en;
    logic               irr_found, isr_found, deliver;
    logic [VW-1:0]      irr_idx, isr_idx, ppr;
    ack_kind_e          ack_kind;
    logic               eoi_hit;

    assign sw_en = cfg_q[VW];

    hi_bit_enc #(.N(NUM_VEC), .WORD(WORD)) u_irr_enc (
        .vec_i(irr_q), .found_o(irr_found), .idx_o(irr_idx));

    hi_bit_enc #(.N(NUM_VEC), .WORD(WORD)) u_isr_enc (
        .vec_i(isr_q), .found_o(isr_found), .idx_o(isr_idx));

    prio_gate #(.VW(VW)) u_gate (
        .tpr_i(tpr_q), .isr_found_i(isr_found), .isr_idx_i(isr_idx),
        .irr_found_i(irr_found), .irr_idx_i(irr_idx),
        .ppr_o(ppr), .deliver_o(deliver));

    // Classify what an acknowledge in this cycle would return.
    always_comb begin
        if (!sw_en || !irr_found) ack_kind = ACK_EMPTY;
        else if (!deliver)        ack_kind = ACK_SPUR;
        else                      ack_kind = ACK_TAKE;
    end

    assign eoi_hit = eoi_we && isr_found;

    // Next vector sets: completion clear, then acknowledge, then request.
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (eoi_hit) isr_d[isr_idx] = 1'b0;
        if (ack_req && ack_kind == ACK_TAKE) begin
            irr_d[irr_idx] = 1'b0;
            isr_d[irr_idx] = 1'b1;
        end
        if (req_valid) begin
            irr_d[req_vec] = 1'b1;
            tmr_d[req_vec] = req_level;
        end
    end

    // State registers: vector sets, task priority and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            isr_q  <= '0;
            tmr_q  <= '0;
            tpr_q  <= '0;
            cfg_q  <= CFG_RST;
            deoi_q <= 1'b0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_we) tpr_q <= tpr_wdata;
            if (cfg_we) begin
                cfg_q  <= cfg_wdata[VW:0];
                deoi_q <= cfg_wdata[DEOI_BIT];
            end
        end
    end

    // Registered outputs: interrupt line, acknowledge result, broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out         <= 1'b0;
            ack_valid       <= 1'b0;
            ack_none        <= 1'b0;
            ack_vec         <= '0;
            eoi_bcast_valid <= 1'b0;
            eoi_bcast_vec   <= '0;
        end else begin
            irq_out         <= sw_en && deliver;
            ack_valid       <= ack_req;
            ack_none        <= ack_req && (ack_kind == ACK_EMPTY);
            ack_vec         <= (ack_kind == ACK_TAKE) ? irr_idx :
                               (ack_kind == ACK_SPUR) ? cfg_q[VW-1:0] : '0;
            eoi_bcast_valid <= eoi_hit && tmr_q[isr_idx] && !deoi_q;
            eoi_bcast_vec   <= isr_idx;
        end
    end

    AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> !irq_out); // R9
    AST_ACK_EMPTY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !sw_en) |=> (ack_valid && ack_none)); // R9
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid); // R5
    AST_BCAST_FROM_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> ($past(eoi_we) && !$past(deoi_q))); // R8
    AST_EMPTY_EOI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && isr_q == '0) |=> !eoi_bcast_valid); // R10
    AST_SPUR_KEEPS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_kind == ACK_SPUR && !req_valid) |=> $stable(irr_q)); // R6
endmodule

// File: tb/irq_prio_core_bench.sv
module irq_prio_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SPUR = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        ack_req = 1'b0;
    logic        ack_valid, ack_none;
    logic [7:0]  ack_vec;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        eoi_we = 1'b0;
    logic        irq_out, eoi_bcast_valid;
    logic [7:0]  eoi_bcast_vec;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_core u_irq_prio_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_none(ack_none), .ack_vec(ack_vec),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .eoi_we(eoi_we), .irq_out(irq_out),
        .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec));

    // Table fields: [18:11] vector, [10] level, [9:2] task priority,
    // [1] expected irq, [0] expected blocked (spurious answer).
    localparam int NT = 8;
    localparam logic [18:0] TBL [NT] = '{
        {8'h45, 1'b0, 8'h00, 1'b1, 1'b0},
        {8'h45, 1'b1, 8'h30, 1'b1, 1'b0},
        {8'h45, 1'b0, 8'h40, 1'b0, 1'b1},
        {8'h45, 1'b1, 8'h4F, 1'b0, 1'b1},
        {8'hFF, 1'b1, 8'hE0, 1'b1, 1'b0},
        {8'h10, 1'b0, 8'h05, 1'b1, 1'b0},
        {8'h0F, 1'b0, 8'h05, 1'b0, 1'b1},
        {8'h0F, 1'b0, 8'h00, 1'b1, 1'b0}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic post(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vec = v; req_level = lvl;
        step();
        req_valid = 1'b0;
    endtask

    task automatic set_tpr(input logic [7:0] v);
        tpr_we = 1'b1; tpr_wdata = v;
        step();
        tpr_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(output logic none, output logic [7:0] v);
        ack_req = 1'b1;
        step();
        ack_req = 1'b0;
        check("R5 ack_valid", int'(ack_valid), 1);
        none = ack_none;
        v = ack_vec;
    endtask

    task automatic do_eoi(output logic bv, output logic [7:0] bvec);
        eoi_we = 1'b1;
        step();
        eoi_we = 1'b0;
        bv = eoi_bcast_valid;
        bvec = eoi_bcast_vec;
    endtask

    task automatic drain();
        logic n, b;
        logic [7:0] v, bvv;
        set_tpr(8'h00);
        for (int k = 0; k < 6; k++) begin
            do_ack(n, v);
            if (n) break;
            do_eoi(b, bvv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic n, b;
        logic [7:0] v, bvec;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state.
        check("R12 reset irq", int'(irq_out), 0);
        check("R8 reset bcast", int'(eoi_bcast_valid), 0);
        check("R5 reset ack_valid", int'(ack_valid), 0);

        // R9: disabled after reset, request stays pending but hidden.
        post(8'h60, 1'b0);
        step();
        check("R9 irq while disabled", int'(irq_out), 0);
        do_ack(n, v);
        check("R9 ack none while disabled", int'(n), 1);
        // Enable: bits above 8 other than 12 dropped, spurious = A5, directed off.
        set_cfg(16'hE1A5);
        step();
        check("R9 irq after enable", int'(irq_out), 1);
        do_ack(n, v);
        check("R7 ack vec 60", int'(v), 'h60);
        do_eoi(b, bvec);
        check("R1 edge no bcast", int'(b), 0);

        // Table walk over class gating.
        for (int t = 0; t < NT; t++) begin
            logic [7:0] tv, tp;
            logic tl, ti, tb;
            {tv, tl, tp, ti, tb} = TBL[t];
            set_tpr(tp);
            post(tv, tl);
            step();
            check($sformatf("R4 tbl%0d irq", t), int'(irq_out), int'(ti));
            do_ack(n, v);
            check($sformatf("R6 tbl%0d ack", t), int'(v), tb ? int'(SPUR) : int'(tv));
            if (!tb) begin
                do_eoi(b, bvec);
                check($sformatf("R1 tbl%0d bcast", t), int'(b), int'(tl));
            end
            drain();
        end

        // R12: irq lags pending set by one edge.
        req_valid = 1'b1; req_vec = 8'h70; req_level = 1'b0;
        step();
        req_valid = 1'b0;
        check("R12 irq not yet", int'(irq_out), 0);
        step();
        check("R12 irq next edge", int'(irq_out), 1);
        drain();

        // R2/R3/R6: highest first, in-service class blocks lower one.
        post(8'h20, 1'b0);
        post(8'h80, 1'b0);
        do_ack(n, v);
        check("R2 highest first", int'(v), 'h80);
        do_ack(n, v);
        check("R3 isr class blocks", int'(v), int'(SPUR));
        do_eoi(b, bvec);
        do_ack(n, v);
        check("R6 pending kept", int'(v), 'h20);
        do_eoi(b, bvec);

        // R8: nested completion retires highest in-service first.
        post(8'h30, 1'b1);
        do_ack(n, v);
        post(8'h90, 1'b0);
        do_ack(n, v);
        check("R7 nested ack", int'(v), 'h90);
        do_eoi(b, bvec);
        check("R8 edge eoi quiet", int'(b), 0);
        do_eoi(b, bvec);
        check("R8 level bcast", int'(b), 1);
        check("R8 bcast vec", int'(bvec), 'h30);

        // R10: completion with nothing in service.
        do_eoi(b, bvec);
        check("R10 empty eoi", int'(b), 0);

        // R8: directed completion suppresses broadcast.
        set_cfg(16'h11A5);
        post(8'h33, 1'b1);
        do_ack(n, v);
        do_eoi(b, bvec);
        check("R8 directed quiet", int'(b), 0);
        set_cfg(16'h01A5);

        // R11: request and acknowledge together.
        req_valid = 1'b1; req_vec = 8'h50; req_level = 1'b0; ack_req = 1'b1;
        step();
        req_valid = 1'b0; ack_req = 1'b0;
        check("R11 ack saw old state", int'(ack_none), 1);
        do_ack(n, v);
        check("R11 request applied after", int'(v), 'h50);
        do_eoi(b, bvec);

        // R8: completion with same-cycle request uses prior trigger bit.
        post(8'h44, 1'b1);
        do_ack(n, v);
        eoi_we = 1'b1; req_valid = 1'b1; req_vec = 8'h44; req_level = 1'b0;
        step();
        eoi_we = 1'b0; req_valid = 1'b0;
        check("R8 eoi with request bcast", int'(eoi_bcast_valid), 1);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule